// File: doc/BRIEF.md
# Serial Analog-Multiplexer Channel Select Receiver

This block sits between a host microcontroller and an analog multiplexer. The host sends a short command over a dedicated serial clock line and data line. The command carries a fixed header and a channel number. The block brings both serial lines into its own system clock domain through synchronizer chains. It detects the falling edges of the serial clock and shifts the data in, most significant bit first. When a packet is complete it checks the header and, if the header is good, loads the channel number into a register that drives the multiplexer select lines.

Commands are honoured only after the host has declared itself alive with a one-cycle set strobe. An assertion of the host reset clears that alive state, and the block then ignores whole packets again. A good packet gives a one-cycle accept pulse. A packet with a bad header gives a one-cycle error pulse and leaves the selection as it was. If the serial clock stays quiet for too long in the middle of a packet, the partial packet is dropped so that framing lines up again with the next command.

Top module: `mux_sel_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `chan_sel` holds RST_SEL (default 0), and `host_alive`, `cmd_ok` and `cmd_err` are 0.
- R2: Data is sampled only at falling edges of `ser_clk`, most significant bit first. The eighth falling edge completes a packet. The result registers update SYNC_STAGES+1 system clock edges after the serial clock falls (3 with the default of 2). `ser_dat` changes while `ser_clk` is high have no effect.
- R3: A completed packet whose bits 7..5 equal 010 while `host_alive` is 1 loads bits 4..0 into `chan_sel` and raises `cmd_ok` for exactly one cycle.
- R4: A completed packet whose bits 7..5 differ from 010 while `host_alive` is 1 leaves `chan_sel` unchanged and raises `cmd_err` for exactly one cycle.
- R5: A completed packet that arrives while `host_alive` is 0 changes nothing: `chan_sel` stays put and neither `cmd_ok` nor `cmd_err` pulses.
- R6: A pulse on `alive_set` sets `host_alive` on the next edge. `host_rst` clears it on the next edge and wins when both are high.
- R7: Once at least one bit of a packet has been received, IDLE_CYC consecutive system clock cycles with no serial falling edge discard the partial packet. The next falling edge then starts a new packet at bit 7.
- R8: `cmd_ok` and `cmd_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst | input | 1 | High while the host reset is asserted; clears the alive state |
| alive_set | input | 1 | One-cycle strobe by which the host declares itself alive |
| ser_clk | input | 1 | Serial command clock, idle high, asynchronous |
| ser_dat | input | 1 | Serial command data, asynchronous |
| chan_sel | output | SEL_W | Registered multiplexer channel select |
| cmd_ok | output | 1 | One-cycle pulse: packet accepted |
| cmd_err | output | 1 | One-cycle pulse: packet rejected for a bad header |
| host_alive | output | 1 | Current alive state |

## Verification
The hardest case to reach from the ports is the idle-timeout resynchronisation. It only shows if a packet is cut off partway through and then followed by a full one. The stimulus sends three bits, waits longer than IDLE_CYC cycles, and then sends a complete valid command. Without a working timeout that command would be misframed and load the wrong channel. A second hard case is a set and a clear of the alive state in the same cycle. The stimulus drives both strobes at once and then sends a command that must be ignored. Data also toggles during every high phase of the serial clock, which shows that only falling-edge samples count.

// File: rtl/msr_pkg.sv
package msr_pkg;

   typedef enum logic [1:0] {
      RES_NONE   = 2'd0,
      RES_ACCEPT = 2'd1,
      RES_REJECT = 2'd2
   } res_e;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msr_framer.sv
module msr_framer #(
   parameter int unsigned PKT_W    = 8,
   parameter int unsigned IDLE_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_clk,
   input  logic             s_dat,
   output logic             word_vld,
   output logic [PKT_W-1:0] word
);
   localparam int unsigned CNT_W = msr_pkg::cnt_w(PKT_W);
   localparam int unsigned IDL_W = msr_pkg::cnt_w(IDLE_CYC);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(PKT_W - 1);
   localparam logic [IDL_W-1:0] IDLE_LAST = IDL_W'(IDLE_CYC - 1);

   generate
      if (PKT_W < 2) begin : g_bad_pkt
         $error("msr_framer: PKT_W must be at least 2");
      end
      if (IDLE_CYC < 2) begin : g_bad_idle
         $error("msr_framer: IDLE_CYC must be at least 2");
      end
   endgenerate

   logic                 prev_q;
   logic                 fall;
   logic [CNT_W-1:0]     bit_q;
   logic [IDL_W-1:0]     idle_q;
   logic [PKT_W-2:0]     sh_q;
   logic [PKT_W-2:0]     sh_d;

   assign fall = prev_q & ~s_clk;

   generate
      if (PKT_W == 2) begin : g_sh_one
         assign sh_d = s_dat;
      end else begin : g_sh_many
         assign sh_d = {sh_q[PKT_W-3:0], s_dat};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         bit_q  <= '0;
         idle_q <= '0;
         sh_q   <= '0;
      end else begin
         prev_q <= s_clk;
         if (fall) begin
            idle_q <= '0;
            sh_q   <= sh_d;
            bit_q  <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
         end else if (bit_q != '0) begin
            if (idle_q == IDLE_LAST) begin
               bit_q  <= '0;
               idle_q <= '0;
            end else begin
               idle_q <= idle_q + 1'b1;
            end
         end
      end
   end

   assign word_vld = fall && (bit_q == BIT_LAST);
   assign word     = {sh_q, s_dat};
endmodule

// File: rtl/msr_decode.sv
module msr_decode #(
   parameter int unsigned         HDR_W   = 3,
   parameter int unsigned         SEL_W   = 5,
   parameter logic [HDR_W-1:0]    HDR_VAL = 3'b010,
   parameter logic [SEL_W-1:0]    RST_SEL = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_rst,
   input  logic                   alive_set,
   input  logic                   word_vld,
   input  logic [HDR_W+SEL_W-1:0] word,
   output logic [SEL_W-1:0]       chan_sel,
   output logic                   cmd_ok,
   output logic                   cmd_err,
   output logic                   host_alive
);
   import msr_pkg::*;

   logic             alive_q;
   logic [SEL_W-1:0] chan_q;
   logic             ok_q;
   logic             err_q;
   res_e             res_d;
   logic [HDR_W-1:0] hdr;
   logic [SEL_W-1:0] sel;

   assign hdr = word[HDR_W+SEL_W-1:SEL_W];
   assign sel = word[SEL_W-1:0];

   always_comb begin
      res_d = RES_NONE;
      if (word_vld && alive_q) begin
         res_d = (hdr == HDR_VAL) ? RES_ACCEPT : RES_REJECT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alive_q <= 1'b0;
         chan_q  <= RST_SEL;
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (host_rst)       alive_q <= 1'b0;
         else if (alive_set) alive_q <= 1'b1;
         if (res_d == RES_ACCEPT) chan_q <= sel;
         ok_q  <= (res_d == RES_ACCEPT);
         err_q <= (res_d == RES_REJECT);
      end
   end

   assign chan_sel   = chan_q;
   assign cmd_ok     = ok_q;
   assign cmd_err    = err_q;
   assign host_alive = alive_q;
endmodule

// File: rtl/mux_sel_rx.sv
module mux_sel_rx #(
   parameter int unsigned      SEL_W       = 5,
   parameter int unsigned      HDR_W       = 3,
   parameter logic [HDR_W-1:0] HDR_VAL     = 3'b010,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      IDLE_CYC    = 64,
   parameter logic [SEL_W-1:0] RST_SEL     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_rst,
   input  logic             alive_set,
   input  logic             ser_clk,
   input  logic             ser_dat,
   output logic [SEL_W-1:0] chan_sel,
   output logic             cmd_ok,
   output logic             cmd_err,
   output logic             host_alive
);
   localparam int unsigned PKT_W = HDR_W + SEL_W;

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("mux_sel_rx: SEL_W must be at least 1");
      end
      if (HDR_W < 1) begin : g_bad_hdr
         $error("mux_sel_rx: HDR_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mux_sel_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             s_clk;
   logic             s_dat;
   logic             word_vld;
   logic [PKT_W-1:0] word;

   msr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(s_clk)
   );

   msr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_dat), .q(s_dat)
   );

   msr_framer #(.PKT_W(PKT_W), .IDLE_CYC(IDLE_CYC)) u_framer (
      .clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_dat(s_dat),
      .word_vld(word_vld), .word(word)
   );

   msr_decode #(.HDR_W(HDR_W), .SEL_W(SEL_W), .HDR_VAL(HDR_VAL), .RST_SEL(RST_SEL)) u_decode (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .alive_set(alive_set),
      .word_vld(word_vld), .word(word),
      .chan_sel(chan_sel), .cmd_ok(cmd_ok), .cmd_err(cmd_err), .host_alive(host_alive)
   );
endmodule

// File: rtl/mux_sel_rx_chk.sv
module mux_sel_rx_chk #(
   parameter int unsigned SEL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_rst,
   input logic             alive_set,
   input logic [SEL_W-1:0] chan_sel,
   input logic             cmd_ok,
   input logic             cmd_err,
   input logic             host_alive
);
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ok && cmd_err));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ok |-> $stable(chan_sel));

   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ok || cmd_err) |-> $past(host_alive));

   assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok |=> !cmd_ok);

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst |=> !host_alive);

   assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_set && !host_rst) |=> host_alive);
endmodule

bind mux_sel_rx mux_sel_rx_chk #(.SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .alive_set(alive_set),
   .chan_sel(chan_sel), .cmd_ok(cmd_ok), .cmd_err(cmd_err), .host_alive(host_alive)
);

// File: tb/mux_sel_rx_bench.sv
`timescale 1ns/1ps
module mux_sel_rx_bench;
   localparam int SYNC = 2;
   localparam int IDLE = 64;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_rst = 1'b0;
   logic       alive_set = 1'b0;
   logic       ser_clk = 1'b1;
   logic       ser_dat = 1'b0;
   logic [4:0] chan_sel;
   logic       cmd_ok;
   logic       cmd_err;
   logic       host_alive;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit finished = 0;
   bit cmp_en = 0;

   always #2 clk = ~clk;

   mux_sel_rx #(.SYNC_STAGES(SYNC), .IDLE_CYC(IDLE)) u_mux_sel_rx (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .alive_set(alive_set),
      .ser_clk(ser_clk), .ser_dat(ser_dat),
      .chan_sel(chan_sel), .cmd_ok(cmd_ok), .cmd_err(cmd_err), .host_alive(host_alive)
   );

   // behavioural reference model
   bit   hc [0:SYNC+1];
   bit   hd [0:SYNC+1];
   int   m_bits, m_idle;
   bit [7:0] m_sh;
   bit [4:0] m_chan;
   bit   m_alive, m_ok, m_err;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         for (int i = 0; i <= SYNC+1; i++) begin hc[i] = 1'b1; hd[i] = 1'b0; end
         m_bits = 0; m_idle = 0; m_sh = '0; m_chan = '0;
         m_alive = 0; m_ok = 0; m_err = 0;
      end else begin
         bit old_alive;
         for (int i = SYNC+1; i > 0; i--) begin hc[i] = hc[i-1]; hd[i] = hd[i-1]; end
         hc[0] = ser_clk; hd[0] = ser_dat;
         old_alive = m_alive;
         m_ok = 0; m_err = 0;
         if (!hc[SYNC] && hc[SYNC+1]) begin
            m_idle = 0;
            m_sh = {m_sh[6:0], hd[SYNC]};
            m_bits++;
            if (m_bits == 8) begin
               m_bits = 0;
               if (old_alive) begin
                  if (m_sh[7:5] == 3'b010) begin m_chan = m_sh[4:0]; m_ok = 1; end
                  else m_err = 1;
               end
            end
         end else if (m_bits != 0) begin
            if (m_idle == IDLE-1) begin m_bits = 0; m_idle = 0; end
            else m_idle++;
         end
         if (host_rst) m_alive = 0;
         else if (alive_set) m_alive = 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !finished) begin
         check(chan_sel == m_chan, "R3 chan_sel per-cycle", chan_sel, m_chan);
         check(cmd_ok == m_ok, "R3 cmd_ok per-cycle", cmd_ok, m_ok);
         check(cmd_err == m_err, "R4 cmd_err per-cycle", cmd_err, m_err);
         check(host_alive == m_alive, "R6 host_alive per-cycle", host_alive, m_alive);
         check(!(cmd_ok && cmd_err), "R8 exclusive pulses", cmd_ok & cmd_err, 0);
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bits(input bit [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         ser_dat = b[i];
         wait_cyc(HALF);
         ser_clk = 1'b0;
         wait_cyc(HALF);
         ser_clk = 1'b1;
         wait_cyc(1);
         ser_dat = ~b[i];   // R2: wiggle while high, must be ignored
         wait_cyc(HALF - 1);
      end
   endtask

   task automatic send(input bit [7:0] b);
      send_bits(b, 8);
      wait_cyc(SYNC + 4);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      wait_cyc(3);
      check(chan_sel == 0, "R1 reset chan_sel", chan_sel, 0);
      check(host_alive == 0 && cmd_ok == 0 && cmd_err == 0, "R1 reset flags",
            {host_alive, cmd_ok, cmd_err}, 0);
      rst_n = 1'b1;
      cmp_en = 1;
      wait_cyc(2);
      check(chan_sel == 0, "R1 after release", chan_sel, 0);

      send(8'h4A);
      check(chan_sel == 0, "R5 not alive ignored", chan_sel, 0);

      alive_set = 1'b1; wait_cyc(1); alive_set = 1'b0; wait_cyc(1);
      check(host_alive == 1, "R6 alive set", host_alive, 1);

      send(8'h4A);
      check(chan_sel == 5'h0A, "R3 accept 0x4A", chan_sel, 5'h0A);
      send(8'h53);
      check(chan_sel == 5'h13, "R2 msb first 0x53", chan_sel, 5'h13);
      send(8'hEA);
      check(chan_sel == 5'h13, "R4 bad header holds", chan_sel, 5'h13);
      send(8'h0A);
      check(chan_sel == 5'h13, "R4 bad header 000", chan_sel, 5'h13);
      send(8'h5F);
      check(chan_sel == 5'h1F, "R3 max channel", chan_sel, 5'h1F);
      send(8'h40);
      check(chan_sel == 5'h00, "R3 channel zero", chan_sel, 5'h00);

      send_bits(8'hFF, 3);
      wait_cyc(IDLE + 20);
      send(8'h45);
      check(chan_sel == 5'h05, "R7 timeout realigns", chan_sel, 5'h05);

      host_rst = 1'b1; alive_set = 1'b1; wait_cyc(1);
      host_rst = 1'b0; alive_set = 1'b0; wait_cyc(1);
      check(host_alive == 0, "R6 clear wins", host_alive, 0);
      send(8'h4C);
      check(chan_sel == 5'h05, "R5 ignored after host reset", chan_sel, 5'h05);

      alive_set = 1'b1; wait_cyc(1); alive_set = 1'b0;
      send(8'h4C);
      check(chan_sel == 5'h0C, "R3 accept after re-alive", chan_sel, 5'h0C);

      wait_cyc(5);
      finish_run();
   end

   initial begin
      while (cycles < 50000 && !finished) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
         finish_run();
      end
   end
endmodule